// File: doc/BRIEF.md
# Converter Configuration and Power-Mode Controller

This block holds the operating configuration of a two-channel current-output converter front end. Software or a host controller places an 8-bit configuration word on the upper eight lines of the channel A sample bus and pulses an active-low write strobe. The strobe runs on its own timing, apart from the sample clock, which may keep running through a write. On the strobe's rising edge the word is latched. A toggle handshake then carries it into the sample-clock domain. There it is decoded into a one-hot power mode (power-down, standby, normal), an interleaved-input enable, a reference-source select and a 4-bit gain-trim code for channel A. The trim code is also given as a signed step count.

A wake-up state machine drives an output-valid flag. The flag drops on the same sample-clock edge on which the mode leaves normal. When the mode returns to normal, the flag rises after a settle time. That time is short when the converter was in standby. It is long when it was in power-down, including power-down followed by standby. The state machine has six states:

- `ST_ACTIVE`: normal and valid.
- `ST_STBY_WARM`: standby entered from normal operation.
- `ST_STBY_COLD`: standby entered from power-down.
- `ST_POWERDN`: power-down.
- `ST_WAKE_WARM`: counting the short settle time.
- `ST_WAKE_COLD`: counting the long settle time.

Its transitions are:

- A power-down request moves any state to `ST_POWERDN`.
- A standby request moves `ST_ACTIVE` and `ST_WAKE_WARM` to `ST_STBY_WARM`, and moves `ST_POWERDN` and `ST_WAKE_COLD` to `ST_STBY_COLD`.
- A normal request moves `ST_STBY_WARM` to `ST_WAKE_WARM`, and moves `ST_STBY_COLD` and `ST_POWERDN` to `ST_WAKE_COLD`.
- A wake state whose counter has reached zero moves to `ST_ACTIVE`.

Top module: `dac_cfg_ctrl`

## Requirements
- R1: After reset the block is in normal mode and valid: mode_norm=1, mode_pd=0, mode_stby=0, ileave_en=0, ext_ref_sel=0, gain_code=4'b1000, gain_trim=0, out_valid=1.
- R2: The word is taken from port_a[9:2] on the rising edge of wr_n, with bit 9 = power-down, bit 8 = converter enable, bit 7 = interleave, bit 6 = external reference, bits 5:2 = gain code. port_a[1:0] are ignored. port_a changes outside a 2.5 ns window around that edge have no effect.
- R3: After a strobe, all outputs move together on one sample-clock edge. That edge is the third rising clk edge after the strobe's rising edge. Between writes the outputs hold.
- R4: Power-down bit 1 gives mode_pd regardless of the other bits. Power-down 0 with enable 0 gives mode_stby. Power-down 0 with enable 1 gives mode_norm. Exactly one mode output is high.
- R5: ileave_en follows the interleave bit, and ext_ref_sel follows the external-reference bit (1 = external reference).
- R6: gain_code is the 4-bit field, and gain_trim = 8 - gain_code as a signed 5-bit count of 0.05 dB steps. Code 0000 gives +8, code 1000 gives 0, and code 1111 gives -7.
- R7: out_valid is low whenever mode_norm is low. It falls on the same edge on which mode_norm falls.
- R8: Going from standby (entered from normal) to normal, out_valid rises exactly CLK_MHZ*STBY_WAKE_NS/1000 clk cycles after mode_norm rises.
- R9: Going from power-down to normal, out_valid rises exactly CLK_MHZ*PD_WAKE_NS/1000 cycles after mode_norm rises.
- R10: Going from power-down through standby to normal still uses the power-down settle time of R9.
- R11: A repeated normal write during a wake does not restart the count. A standby write during a warm wake keeps out_valid low, and the next normal write waits a full R8 period.
- R12: Writing another normal-mode word while valid (for example a new gain) keeps out_valid high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| wr_n | input | 1 | Active-low configuration write strobe, latches on rising edge |
| port_a | input | 10 | Channel A sample bus carrying the configuration word in bits 9:2 |
| mode_pd | output | 1 | Power-down mode |
| mode_stby | output | 1 | Standby mode |
| mode_norm | output | 1 | Normal operating mode |
| ileave_en | output | 1 | Interleaved input enable |
| ext_ref_sel | output | 1 | 1 = external reference, 0 = internal |
| gain_code | output | 4 | Raw channel A gain-trim code |
| gain_trim | output | 5 | Signed trim, 8 - code, in 0.05 dB steps |
| out_valid | output | 1 | Output settled and valid |

## Verification
The hardest case to reach from the ports is a cold wake that passes through standby. It needs power-down, then standby, then normal, with the last count timed against the long limit. A related hard case is a normal write landing in the middle of a running wake count. The bench reaches both with directed write sequences and records the time at which mode_norm rose and the time at which out_valid rose. For the mid-wake case, it issues the repeat write a fixed number of cycles into the count. Constrained-random words with random don't-care bits, and with data scrambled before and after the strobe window, exercise decoding and capture between these sequences.

// File: rtl/dac_cfg_pkg.sv
package dac_cfg_pkg;

    localparam int CW_W   = 8;
    localparam int GAIN_W = 4;

    typedef enum logic [1:0] {
        MODE_NORM = 2'd0,
        MODE_STBY = 2'd1,
        MODE_PD   = 2'd2
    } pmode_e;

    typedef struct packed {
        logic              pd;
        logic              dac_on;
        logic              ileave;
        logic              ext_ref;
        logic [GAIN_W-1:0] gain;
    } cfg_word_t;

    localparam cfg_word_t CFG_DEFAULT = '{pd: 1'b0, dac_on: 1'b1, ileave: 1'b0,
                                          ext_ref: 1'b0, gain: 4'b1000};

    typedef enum logic [2:0] {
        ST_ACTIVE    = 3'd0,
        ST_STBY_WARM = 3'd1,
        ST_STBY_COLD = 3'd2,
        ST_POWERDN   = 3'd3,
        ST_WAKE_WARM = 3'd4,
        ST_WAKE_COLD = 3'd5
    } wake_st_e;

    function automatic pmode_e decode_mode(input cfg_word_t w);
        if (w.pd)
            return MODE_PD;
        else if (w.dac_on)
            return MODE_NORM;
        else
            return MODE_STBY;
    endfunction

endpackage

// File: rtl/cfg_capture.sv
module cfg_capture
    import dac_cfg_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              wr_n,
    input  logic              rst_n,
    input  logic [CW_W-1:0]   word_bits,
    output cfg_word_t         word_o,
    output logic              tog_o
);

    cfg_word_t word_q;
    logic      tog_q;

    // Strobe domain: latch on the rising (trailing) edge of the write strobe.
    always_ff @(posedge wr_n or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= CFG_DEFAULT;
            tog_q  <= 1'b0;
        end else begin
            word_q <= cfg_word_t'(word_bits);
            tog_q  <= ~tog_q;
        end
    end

    assign word_o = word_q;
    assign tog_o  = tog_q;

endmodule

// File: rtl/cfg_sync.sv
module cfg_sync
    import dac_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  cfg_word_t word_i,
    input  logic      tog_i,
    output cfg_word_t cfg_o,
    output logic      load_o
);

    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_q;
    cfg_word_t       cfg_q;
    logic            load;

    // sh_q[0..SYNC_STAGES-1] synchronise, sh_q[SYNC_STAGES] holds the prior value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sh_q <= '0;
        else
            sh_q <= {sh_q[SH_W-2:0], tog_i};
    end

    assign load = sh_q[SYNC_STAGES] ^ sh_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= CFG_DEFAULT;
        else if (load)
            cfg_q <= word_i;
    end

    assign cfg_o  = cfg_q;
    assign load_o = load;

    assert_hold_between_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cfg_q));

    assert_load_takes_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cfg_q == $past(word_i));

endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
    import dac_cfg_pkg::*;
#(
    parameter int STBY_CYC = 750,
    parameter int PD_CYC   = 125000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  pmode_e req,
    output logic   valid
);

    localparam int MAX_CYC = (PD_CYC > STBY_CYC) ? PD_CYC : STBY_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] STBY_LOAD = CNT_W'(STBY_CYC - 2);
    localparam logic [CNT_W-1:0] PD_LOAD   = CNT_W'(PD_CYC - 2);

    wake_st_e         state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (req == MODE_PD)        state_d = ST_POWERDN;
                else if (req == MODE_STBY) state_d = ST_STBY_WARM;
            end
            ST_STBY_WARM: begin
                if (req == MODE_PD) state_d = ST_POWERDN;
                else if (req == MODE_NORM) begin
                    state_d = ST_WAKE_WARM;
                    cnt_d   = STBY_LOAD;
                end
            end
            ST_STBY_COLD: begin
                if (req == MODE_PD) state_d = ST_POWERDN;
                else if (req == MODE_NORM) begin
                    state_d = ST_WAKE_COLD;
                    cnt_d   = PD_LOAD;
                end
            end
            ST_POWERDN: begin
                if (req == MODE_STBY) state_d = ST_STBY_COLD;
                else if (req == MODE_NORM) begin
                    state_d = ST_WAKE_COLD;
                    cnt_d   = PD_LOAD;
                end
            end
            ST_WAKE_WARM: begin
                if (req == MODE_PD)        state_d = ST_POWERDN;
                else if (req == MODE_STBY) state_d = ST_STBY_WARM;
                else if (cnt_q == '0)      state_d = ST_ACTIVE;
                else                       cnt_d   = cnt_q - 1'b1;
            end
            ST_WAKE_COLD: begin
                if (req == MODE_PD)        state_d = ST_POWERDN;
                else if (req == MODE_STBY) state_d = ST_STBY_COLD;
                else if (cnt_q == '0)      state_d = ST_ACTIVE;
                else                       cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_POWERDN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output process: valid only when settled and still asked for normal.
    always_comb begin
        valid = (state_q == ST_ACTIVE) && (req == MODE_NORM);
    end

    assert_wake_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAKE_WARM || state_q == ST_WAKE_COLD) && req == MODE_NORM && cnt_q != '0)
        |=> cnt_q == $past(cnt_q) - 1'b1);

    assert_active_after_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_ACTIVE)
        |-> ($past(cnt_q) == '0 && ($past(state_q) == ST_WAKE_WARM || $past(state_q) == ST_WAKE_COLD)));

    assert_cold_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_POWERDN || state_q == ST_STBY_COLD) && req == MODE_NORM)
        |=> (state_q == ST_WAKE_COLD && cnt_q == PD_LOAD));

endmodule

// File: rtl/dac_cfg_ctrl.sv
module dac_cfg_ctrl
    import dac_cfg_pkg::*;
#(
    parameter int DATA_W       = 10,
    parameter int CLK_MHZ      = 250,
    parameter int STBY_WAKE_NS = 3000,
    parameter int PD_WAKE_NS   = 500000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_n,
    input  logic [DATA_W-1:0]        port_a,
    output logic                     mode_pd,
    output logic                     mode_stby,
    output logic                     mode_norm,
    output logic                     ileave_en,
    output logic                     ext_ref_sel,
    output logic [GAIN_W-1:0]        gain_code,
    output logic signed [GAIN_W:0]   gain_trim,
    output logic                     out_valid
);

    localparam int STBY_CYC = CLK_MHZ * STBY_WAKE_NS / 1000;
    localparam int PD_CYC   = CLK_MHZ * PD_WAKE_NS / 1000;
    localparam int LSB_W    = DATA_W - CW_W;
    localparam logic signed [GAIN_W:0] TRIM_ZERO = (GAIN_W + 1)'(1 << (GAIN_W - 1));

    cfg_word_t cap_word, cfg;
    logic      cap_tog, load;
    pmode_e    mode;
    logic      unused_lsbs;

    assign unused_lsbs = ^port_a[LSB_W-1:0];

    cfg_capture #(.DATA_W(DATA_W)) u_capture (
        .wr_n      (wr_n),
        .rst_n     (rst_n),
        .word_bits (port_a[DATA_W-1 -: CW_W]),
        .word_o    (cap_word),
        .tog_o     (cap_tog)
    );

    cfg_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_i (cap_word),
        .tog_i  (cap_tog),
        .cfg_o  (cfg),
        .load_o (load)
    );

    assign mode = decode_mode(cfg);

    wake_fsm #(.STBY_CYC(STBY_CYC), .PD_CYC(PD_CYC)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (mode),
        .valid (out_valid)
    );

    always_comb begin
        mode_pd   = 1'b0;
        mode_stby = 1'b0;
        mode_norm = 1'b0;
        unique case (mode)
            MODE_PD:   mode_pd   = 1'b1;
            MODE_STBY: mode_stby = 1'b1;
            MODE_NORM: mode_norm = 1'b1;
            default:   mode_pd   = 1'b1;
        endcase
    end

    assign ileave_en   = cfg.ileave;
    assign ext_ref_sel = cfg.ext_ref;
    assign gain_code   = cfg.gain;
    assign gain_trim   = TRIM_ZERO - $signed({1'b0, cfg.gain});

    assert_valid_needs_norm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> mode_norm);

    assert_one_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({mode_pd, mode_stby, mode_norm}));

    assert_modes_follow_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(mode_norm) && $stable(gain_code)));

endmodule

// File: tb/tb_dac_cfg_ctrl.sv
`timescale 1ns/1ps
module tb_dac_cfg_ctrl;

    localparam int CLK_MHZ  = 250;
    localparam int STBY_NS  = 3000;
    localparam int PD_NS    = 20000;
    localparam int STBY_CYC = CLK_MHZ * STBY_NS / 1000;
    localparam int PD_CYC   = CLK_MHZ * PD_NS / 1000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_n = 1'b1;
    logic [9:0]       port_a = '0;
    logic             mode_pd, mode_stby, mode_norm, ileave_en, ext_ref_sel, out_valid;
    logic [3:0]       gain_code;
    logic signed [4:0] gain_trim;

    int n_cmp = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dac_cfg_ctrl #(.CLK_MHZ(CLK_MHZ), .STBY_WAKE_NS(STBY_NS), .PD_WAKE_NS(PD_NS)) dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .port_a(port_a),
        .mode_pd(mode_pd), .mode_stby(mode_stby), .mode_norm(mode_norm),
        .ileave_en(ileave_en), .ext_ref_sel(ext_ref_sel),
        .gain_code(gain_code), .gain_trim(gain_trim), .out_valid(out_valid)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    // 0 = normal, 1 = standby, 2 = power-down
    function automatic int exp_mode(input logic [9:0] d);
        if (d[9]) return 2;
        if (d[8]) return 0;
        return 1;
    endfunction

    function automatic int cur_mode();
        return mode_norm ? 0 : (mode_stby ? 1 : (mode_pd ? 2 : 3));
    endfunction

    // Strobe: low 6 ns, data setup 5 ns, hold 3 ns, junk before and after.
    task automatic strobe(input logic [9:0] d);
        @(negedge clk);
        #1 wr_n = 1'b0; port_a = ~d;
        #1 port_a = d;
        #5 wr_n = 1'b1;
        #3 port_a = 10'($urandom);
    endtask

    task automatic write_settle(input logic [9:0] d);
        strobe(d);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_fields(input string rq, input logic [9:0] d);
        chk({rq, " R4 mode"}, cur_mode(), exp_mode(d));
        chk({rq, " R5 ileave"}, int'(ileave_en), int'(d[7]));
        chk({rq, " R5 extref"}, int'(ext_ref_sel), int'(d[6]));
        chk({rq, " R6 code"}, int'(gain_code), int'(d[5:2]));
        chk({rq, " R6 trim"}, int'(gain_trim), 8 - int'(d[5:2]));
    endtask

    // Returns cycles from mode_norm rising to out_valid rising.
    task automatic measure_wake(output int cycles);
        time t_n;
        int  guard;
        guard = 0;
        while (!mode_norm && guard < 100) begin @(negedge clk); guard++; end
        t_n = $time;
        chk("R7 valid low at wake start", int'(out_valid), 0);
        guard = 0;
        while (!out_valid && guard < PD_CYC + 100) begin @(negedge clk); guard++; end
        cycles = int'(($time - t_n) / 4);
    endtask

    initial begin
        int cyc;
        time t_n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1 norm", int'(mode_norm), 1);
        chk("R1 pd", int'(mode_pd), 0);
        chk("R1 stby", int'(mode_stby), 0);
        chk("R1 ileave", int'(ileave_en), 0);
        chk("R1 extref", int'(ext_ref_sel), 0);
        chk("R1 code", int'(gain_code), 8);
        chk("R1 trim", int'(gain_trim), 0);
        chk("R1 valid", int'(out_valid), 1);

        // R3 exact edge of change; R2 ignored low bits and junk outside window
        strobe(10'b01_1_1_0011_11);
        @(negedge clk); chk("R3 held 1", int'(gain_code), 8);
        @(negedge clk); chk("R3 held 2", int'(gain_code), 8);
        @(negedge clk);
        chk("R3 together code", int'(gain_code), 3);
        chk("R3 together ileave", int'(ileave_en), 1);
        check_fields("R2 capture", 10'b01_1_1_0011_11);
        repeat (5) @(negedge clk);
        check_fields("R2 junk after hold", 10'b01_1_1_0011_00);

        // R12 normal to normal keeps valid high
        strobe(10'b01_0_0_0101_10);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R12 valid stays", int'(out_valid), 1);
        end
        check_fields("R12 fields", 10'b01_0_0_0101_00);

        // R6 gain corners, R4 priority
        write_settle(10'b01_0_0_0000_00);
        chk("R6 trim max", int'(gain_trim), 8);
        write_settle(10'b01_0_0_1111_01);
        chk("R6 trim min", int'(gain_trim), -7);
        write_settle(10'b11_0_0_1000_00);
        chk("R4 pd overrides enable", int'(mode_pd), 1);
        chk("R7 valid in pd", int'(out_valid), 0);

        // Constrained random words
        for (int i = 0; i < 30; i++) begin
            logic [9:0] d;
            d = 10'($urandom);
            write_settle(d);
            check_fields("rand", d);
            if (!mode_norm) chk("R7 rand valid", int'(out_valid), 0);
        end

        // R8 warm wake, with R7 same-edge drop
        write_settle(10'b01_0_0_1000_00);
        while (!out_valid) @(negedge clk);
        strobe(10'b00_0_0_1000_00);
        while (!mode_stby) begin
            @(negedge clk);
            chk("R7 same edge", int'(out_valid), int'(mode_norm));
        end
        chk("R7 standby drops valid", int'(out_valid), 0);
        strobe(10'b01_0_0_1000_00);
        measure_wake(cyc);
        chk("R8 warm wake cycles", cyc, STBY_CYC);

        // R9 power-down to normal
        write_settle(10'b10_0_0_1000_00);
        strobe(10'b01_0_0_1000_00);
        measure_wake(cyc);
        chk("R9 cold wake cycles", cyc, PD_CYC);

        // R10 power-down, standby, normal
        write_settle(10'b10_0_0_1000_00);
        write_settle(10'b00_0_0_1000_00);
        chk("R10 standby", int'(mode_stby), 1);
        strobe(10'b01_0_0_1000_00);
        measure_wake(cyc);
        chk("R10 cold via standby", cyc, PD_CYC);

        // R11 repeated normal write mid-wake does not restart
        write_settle(10'b00_0_0_1000_00);
        strobe(10'b01_0_0_1000_00);
        while (!mode_norm) @(negedge clk);
        t_n = $time;
        repeat (100) @(negedge clk);
        strobe(10'b01_0_0_0010_00);
        while (!out_valid && ($time - t_n) < 4 * (PD_CYC + 100)) @(negedge clk);
        chk("R11 no restart", int'(($time - t_n) / 4), STBY_CYC);
        chk("R11 new gain", int'(gain_code), 2);

        // R11 standby interrupts warm wake
        write_settle(10'b00_0_0_1000_00);
        strobe(10'b01_0_0_1000_00);
        repeat (200) @(negedge clk);
        write_settle(10'b00_0_0_1000_00);
        repeat (STBY_CYC) @(negedge clk);
        chk("R11 interrupted stays low", int'(out_valid), 0);
        strobe(10'b01_0_0_1000_00);
        measure_wake(cyc);
        chk("R11 full wake after interrupt", cyc, STBY_CYC);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_cmp++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

endmodule